// File: doc/BRIEF.md
# Slot-Based Multi-Rail Enable Sequencer

This block drives twelve rail-enable levels through four ordered time slots. Four sequences are supported: power-up, power-down, sleep-entry and sleep-exit. Each has its own slot-by-rail map, so a given rail can be switched in a different slot, or not at all, in each sequence. Power-up and sleep-exit raise the mapped enables and time their slots from the up-timing fields. Power-down and sleep-entry lower the mapped enables and use the down-timing fields. A shared step-select bit scales every slot field.

Time is counted in pulses on a time-base input, one pulse per base interval. A 2-bit state code reports whether the rails are off, active, asleep, or in the middle of a sequence. A request that arrives while a sequence runs is held and evaluated once that sequence has finished. The enable register is itself the readback of the present drive levels.

Top module: `rail_seq`

## Requirements
- R1: After reset `rail_en_o` is all zero, `state_o` is 2'b00 (off) and no request is held.
- R2: When no sequence runs, a request is accepted only if it is legal for the resting state: power-up from off (00); power-down or sleep-entry from active (01); power-down or sleep-exit from sleep (10). Other requests are ignored and change neither output.
- R3: A sequence runs slots 0, 1, 2, 3 in order. Slot 0 begins at the clock edge that samples the accepted request. Each later slot begins at the edge that samples the time-base pulse ending the previous slot. The rails mapped to a slot change at the edge on which that slot begins.
- R4: A slot field f (4 bits, slot s at bits [4s+3:4s]) lasts 1 time-base pulse when f = 0, and otherwise f×2 pulses (`step_sel_i` = 0) or f×8 pulses (`step_sel_i` = 1). A pulse sampled at the edge that starts a slot does not count toward that slot.
- R5: Map bit s*12+r places rail r in slot s. Power-up (`map_up_i`) and sleep-exit (`map_wake_i`) set their mapped rails to 1 and use `up_time_i`. Power-down (`map_dn_i`) and sleep-entry (`map_nap_i`) clear their mapped rails to 0 and use `dn_time_i`.
- R6: A rail that is not mapped in any slot of the running sequence keeps its level. No enable changes while no sequence runs.
- R7: `state_o` is 2'b11 from the start edge until the edge that ends slot 3. At that edge it becomes 01 after power-up or sleep-exit, 10 after sleep-entry, and 00 after power-down.
- R8: Requests sampled while a sequence runs are held. In the first idle cycle after completion, the legal held request of highest priority starts, with priority power-down > sleep-entry > sleep-exit > power-up. All other held requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base pulse, one per base interval |
| step_sel_i | input | 1 | Step scale: 0 gives 2 pulses per step, 1 gives 8 |
| req_up_i | input | 1 | Power-up request pulse |
| req_dn_i | input | 1 | Power-down request pulse |
| req_nap_i | input | 1 | Sleep-entry request pulse |
| req_wake_i | input | 1 | Sleep-exit request pulse |
| up_time_i | input | 16 | Up-direction slot fields, 4 bits per slot |
| dn_time_i | input | 16 | Down-direction slot fields, 4 bits per slot |
| map_up_i | input | 48 | Power-up slot-by-rail map |
| map_dn_i | input | 48 | Power-down slot-by-rail map |
| map_nap_i | input | 48 | Sleep-entry slot-by-rail map |
| map_wake_i | input | 48 | Sleep-exit slot-by-rail map |
| rail_en_o | output | 12 | Registered rail enable levels |
| state_o | output | 2 | 00 off, 01 active, 10 sleep, 11 sequencing |

## Verification
The assertions take the maps, slot fields and step select to be held steady for the whole of a running sequence. They also take request pins to be single-cycle pulses sampled on the clock. Under these conditions a raising sequence never clears a rail and a lowering one never sets one. The stimulus changes configuration only while the state code is at rest. It pulses requests for exactly one cycle and supplies time-base pulses on every cycle, at random, or not at all.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    SEQ_UP   = 2'd0,
    SEQ_DOWN = 2'd1,
    SEQ_NAP  = 2'd2,
    SEQ_WAKE = 2'd3
  } seq_kind_t;

  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_ON  = 2'b01,
    ST_NAP = 2'b10,
    ST_RUN = 2'b11
  } st_code_t;

  function automatic logic kind_raises(seq_kind_t k);
    return (k == SEQ_UP) || (k == SEQ_WAKE);
  endfunction

endpackage

// File: rtl/rseq_map_sel.sv
module rseq_map_sel
  import rseq_pkg::*;
#(
  parameter int N_RAIL = 12,
  parameter int N_SLOT = 4,
  parameter int TW     = 4,
  parameter int SW     = $clog2(N_SLOT)
) (
  input  seq_kind_t                  kind_i,
  input  logic [SW-1:0]              slot_i,
  input  logic [N_SLOT*N_RAIL-1:0]   map_up_i,
  input  logic [N_SLOT*N_RAIL-1:0]   map_dn_i,
  input  logic [N_SLOT*N_RAIL-1:0]   map_nap_i,
  input  logic [N_SLOT*N_RAIL-1:0]   map_wake_i,
  input  logic [N_SLOT*TW-1:0]       up_time_i,
  input  logic [N_SLOT*TW-1:0]       dn_time_i,
  output logic [N_RAIL-1:0]          row_o,
  output logic [TW-1:0]              field_o,
  output logic                       raise_o
);

  logic [N_RAIL-1:0] up_rows   [N_SLOT];
  logic [N_RAIL-1:0] dn_rows   [N_SLOT];
  logic [N_RAIL-1:0] nap_rows  [N_SLOT];
  logic [N_RAIL-1:0] wake_rows [N_SLOT];
  logic [TW-1:0]     up_f      [N_SLOT];
  logic [TW-1:0]     dn_f      [N_SLOT];

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    assign up_rows[s]   = map_up_i[s*N_RAIL +: N_RAIL];
    assign dn_rows[s]   = map_dn_i[s*N_RAIL +: N_RAIL];
    assign nap_rows[s]  = map_nap_i[s*N_RAIL +: N_RAIL];
    assign wake_rows[s] = map_wake_i[s*N_RAIL +: N_RAIL];
    assign up_f[s]      = up_time_i[s*TW +: TW];
    assign dn_f[s]      = dn_time_i[s*TW +: TW];
  end

  always_comb begin
    raise_o = kind_raises(kind_i);
    case (kind_i)
      SEQ_UP:   row_o = up_rows[slot_i];
      SEQ_DOWN: row_o = dn_rows[slot_i];
      SEQ_NAP:  row_o = nap_rows[slot_i];
      default:  row_o = wake_rows[slot_i];
    endcase
    field_o = raise_o ? up_f[slot_i] : dn_f[slot_i];
  end

endmodule

// File: rtl/rseq_slot_timer.sv
module rseq_slot_timer #(
  parameter int TW         = 4,
  parameter int STEP_SHORT = 2,
  parameter int STEP_LONG  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] field_i,
  input  logic          step_sel_i,
  input  logic          tick_i,
  output logic          expire_o
);

  localparam int DMAX = ((1 << TW) - 1) * STEP_LONG;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dur;

  always_comb begin
    if (field_i == '0) dur = CW'(1);
    else dur = CW'(field_i) * (step_sel_i ? CW'(STEP_LONG) : CW'(STEP_SHORT));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_i) cnt_q <= dur;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign expire_o = tick_i && (cnt_q == CW'(1));

  // R4: a loaded slot always lasts at least one pulse and never beyond the longest field
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q != '0));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DMAX));
  // R6: an idle timer stays idle until the controller loads it
  a_r6_idle_timer: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int SW     = $clog2(N_SLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    req_i,
  input  logic          expire_i,
  output logic          load_o,
  output seq_kind_t     next_kind_o,
  output logic [SW-1:0] next_slot_o,
  output seq_kind_t     cur_kind_o,
  output logic          busy_o,
  output st_code_t      st_o
);

  logic          busy_q;
  seq_kind_t     kind_q;
  logic [SW-1:0] slot_q;
  st_code_t      rest_q, rest_nx, st_q;
  logic [3:0]    pend_q, cand, legal, avail;
  seq_kind_t     sel;
  logic          start, advance, finish, last;

  always_comb begin
    cand  = pend_q | req_i;
    legal = '0;
    case (rest_q)
      ST_OFF:  legal[SEQ_UP] = 1'b1;
      ST_ON:   begin legal[SEQ_DOWN] = 1'b1; legal[SEQ_NAP]  = 1'b1; end
      ST_NAP:  begin legal[SEQ_DOWN] = 1'b1; legal[SEQ_WAKE] = 1'b1; end
      default: legal = '0;
    endcase
    avail = cand & legal;
    if (avail[SEQ_DOWN])      sel = SEQ_DOWN;
    else if (avail[SEQ_NAP])  sel = SEQ_NAP;
    else if (avail[SEQ_WAKE]) sel = SEQ_WAKE;
    else                      sel = SEQ_UP;

    last    = (slot_q == SW'(N_SLOT - 1));
    start   = !busy_q && (avail != '0);
    advance = busy_q && expire_i && !last;
    finish  = busy_q && expire_i && last;

    case (kind_q)
      SEQ_DOWN: rest_nx = ST_OFF;
      SEQ_NAP:  rest_nx = ST_NAP;
      default:  rest_nx = ST_ON;
    endcase

    load_o      = start || advance;
    next_kind_o = start ? sel : kind_q;
    next_slot_o = start ? '0 : slot_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= SEQ_UP;
      slot_q <= '0;
      rest_q <= ST_OFF;
      st_q   <= ST_OFF;
      pend_q <= '0;
    end else begin
      if (busy_q) pend_q <= pend_q | req_i;
      else        pend_q <= '0;
      if (start) begin
        busy_q <= 1'b1;
        kind_q <= sel;
        slot_q <= '0;
        st_q   <= ST_RUN;
      end else if (advance) begin
        slot_q <= slot_q + SW'(1);
      end else if (finish) begin
        busy_q <= 1'b0;
        rest_q <= rest_nx;
        st_q   <= rest_nx;
      end
    end
  end

  assign cur_kind_o = kind_q;
  assign busy_o     = busy_q;
  assign st_o       = st_q;

  // R2: leaving the off state is only possible by starting a sequence
  a_r2_off_exit: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_RUN));
  // R7: a running sequence reports 11 until its timer expires
  a_r7_run_until_expiry: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !expire_i) |=> (st_q == ST_RUN));
  a_r7_code_tracks_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q == (st_q == ST_RUN));
  // R3: the slot index only moves on an expiry
  a_r3_slot_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !expire_i) |=> $stable(slot_q));
  // R8: held requests never survive an idle cycle
  a_r8_pend_flushed: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> (pend_q == '0));

endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rseq_pkg::*;
#(
  parameter int N_RAIL     = 12,
  parameter int N_SLOT     = 4,
  parameter int TW         = 4,
  parameter int STEP_SHORT = 2,
  parameter int STEP_LONG  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic                     step_sel_i,
  input  logic                     req_up_i,
  input  logic                     req_dn_i,
  input  logic                     req_nap_i,
  input  logic                     req_wake_i,
  input  logic [N_SLOT*TW-1:0]     up_time_i,
  input  logic [N_SLOT*TW-1:0]     dn_time_i,
  input  logic [N_SLOT*N_RAIL-1:0] map_up_i,
  input  logic [N_SLOT*N_RAIL-1:0] map_dn_i,
  input  logic [N_SLOT*N_RAIL-1:0] map_nap_i,
  input  logic [N_SLOT*N_RAIL-1:0] map_wake_i,
  output logic [N_RAIL-1:0]        rail_en_o,
  output logic [1:0]               state_o
);

  localparam int SW = $clog2(N_SLOT);

  logic [3:0]        req;
  logic              load, expire, busy, raise;
  seq_kind_t         next_kind, cur_kind;
  logic [SW-1:0]     next_slot;
  logic [N_RAIL-1:0] row;
  logic [TW-1:0]     field;
  st_code_t          st;
  logic [N_RAIL-1:0] en_q;

  always_comb begin
    req           = '0;
    req[SEQ_UP]   = req_up_i;
    req[SEQ_DOWN] = req_dn_i;
    req[SEQ_NAP]  = req_nap_i;
    req[SEQ_WAKE] = req_wake_i;
  end

  rseq_ctrl #(.N_SLOT(N_SLOT), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .expire_i(expire),
    .load_o(load), .next_kind_o(next_kind), .next_slot_o(next_slot),
    .cur_kind_o(cur_kind), .busy_o(busy), .st_o(st)
  );

  rseq_map_sel #(.N_RAIL(N_RAIL), .N_SLOT(N_SLOT), .TW(TW), .SW(SW)) u_sel (
    .kind_i(next_kind), .slot_i(next_slot),
    .map_up_i(map_up_i), .map_dn_i(map_dn_i), .map_nap_i(map_nap_i), .map_wake_i(map_wake_i),
    .up_time_i(up_time_i), .dn_time_i(dn_time_i),
    .row_o(row), .field_o(field), .raise_o(raise)
  );

  rseq_slot_timer #(.TW(TW), .STEP_SHORT(STEP_SHORT), .STEP_LONG(STEP_LONG)) u_timer (
    .clk(clk), .rst(rst), .load_i(load), .field_i(field),
    .step_sel_i(step_sel_i), .tick_i(tick_i), .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (load) en_q <= raise ? (en_q | row) : (en_q & ~row);
  end

  assign rail_en_o = en_q;
  assign state_o   = st;

  // R5: a raising sequence never clears a rail, a lowering one never sets one
  a_r5_up_only_sets: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_raises(cur_kind)) |=> (($past(en_q) & ~en_q) == '0));
  a_r5_down_only_clears: assert property (@(posedge clk) disable iff (rst)
    (busy && !kind_raises(cur_kind)) |=> ((~$past(en_q) & en_q) == '0));
  // R6: no enable moves while idle and nothing starts
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(en_q));

endmodule

// File: tb/test_rail_seq.sv
`timescale 1ns/1ps
module test_rail_seq;
  localparam int NR = 12;
  localparam int NS = 4;
  localparam int TW = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, step_sel = 1'b0;
  logic rq_up = 1'b0, rq_dn = 1'b0, rq_nap = 1'b0, rq_wake = 1'b0;
  logic [NS*NR-1:0] m_up = '0, m_dn = '0, m_nap = '0, m_wake = '0;
  logic [NS*TW-1:0] t_up = '0, t_dn = '0;
  wire  [NR-1:0] en;
  wire  [1:0]    st;

  always #2.5 clk = ~clk;

  rail_seq i_rail_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .step_sel_i(step_sel),
    .req_up_i(rq_up), .req_dn_i(rq_dn), .req_nap_i(rq_nap), .req_wake_i(rq_wake),
    .up_time_i(t_up), .dn_time_i(t_dn),
    .map_up_i(m_up), .map_dn_i(m_dn), .map_nap_i(m_nap), .map_wake_i(m_wake),
    .rail_en_o(en), .state_o(st)
  );

  int checks = 0, failures = 0, tick_mode = 0;
  string tag = "R1";

  // reference model: kinds 0 up, 1 down, 2 sleep-entry, 3 sleep-exit; rest 0 off, 1 active, 2 sleep
  int mrest = 0, mbusy = 0, mkind = 0, mslot = 0, mcnt = 0, pick;
  int mpend[4], rq[4];
  int order[4] = '{1, 2, 3, 0};
  logic [NR-1:0] men = '0;

  function automatic int f_dur(int k, int s);
    int f;
    f = (k == 0 || k == 3) ? int'(t_up[s*TW +: TW]) : int'(t_dn[s*TW +: TW]);
    return (f == 0) ? 1 : f * (step_sel ? 8 : 2);
  endfunction

  function automatic bit f_legal(int k);
    if (mrest == 0) return k == 0;
    if (mrest == 1) return k == 1 || k == 2;
    return k == 1 || k == 3;
  endfunction

  task automatic m_apply(int k, int s);
    logic [NR-1:0] r;
    case (k)
      0: r = m_up[s*NR +: NR];
      1: r = m_dn[s*NR +: NR];
      2: r = m_nap[s*NR +: NR];
      default: r = m_wake[s*NR +: NR];
    endcase
    if (k == 0 || k == 3) men = men | r;
    else men = men & ~r;
  endtask

  always @(posedge clk) begin
    rq[0] = int'(rq_up); rq[1] = int'(rq_dn); rq[2] = int'(rq_nap); rq[3] = int'(rq_wake);
    if (rst) begin
      mrest = 0; mbusy = 0; mslot = 0; mcnt = 0; men = '0;
      for (int k = 0; k < 4; k++) mpend[k] = 0;
    end else if (mbusy == 0) begin
      pick = -1;
      for (int i = 0; i < 4; i++)
        if (pick < 0 && (mpend[order[i]] != 0 || rq[order[i]] != 0) && f_legal(order[i]))
          pick = order[i];
      for (int k = 0; k < 4; k++) mpend[k] = 0;
      if (pick >= 0) begin
        mbusy = 1; mkind = pick; mslot = 0;
        m_apply(pick, 0);
        mcnt = f_dur(pick, 0);
      end
    end else begin
      for (int k = 0; k < 4; k++) if (rq[k] != 0) mpend[k] = 1;
      if (tick) begin
        if (mcnt == 1) begin
          if (mslot == NS - 1) begin
            mbusy = 0;
            mrest = (mkind == 1) ? 0 : (mkind == 2) ? 2 : 1;
          end else begin
            mslot = mslot + 1;
            m_apply(mkind, mslot);
            mcnt = f_dur(mkind, mslot);
          end
        end else mcnt = mcnt - 1;
      end
    end
  end

  task automatic chk(string name, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", name, act, expv);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({tag, " R3 R5 R6 enables"}, int'(en), int'(men));
      chk({tag, " R7 state"}, int'(st), (mbusy != 0) ? 3 : mrest);
    end
  end

  always @(negedge clk) begin
    if (tick_mode == 0) tick <= 1'b1;
    else if (tick_mode == 1) tick <= ($urandom_range(2) == 0);
    else tick <= 1'b0;
  end

  task automatic pulse(int k);
    @(negedge clk);
    rq_up = (k == 0); rq_dn = (k == 1); rq_nap = (k == 2); rq_wake = (k == 3);
    @(negedge clk);
    rq_up = 0; rq_dn = 0; rq_nap = 0; rq_wake = 0;
  endtask

  task automatic wait_st(logic [1:0] want);
    int n = 0;
    while (st !== want && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic timed_run(int k, logic [1:0] want, output int n);
    @(negedge clk);
    rq_up = (k == 0); rq_dn = (k == 1);
    @(negedge clk);
    rq_up = 0; rq_dn = 0;
    n = 1;
    while (st !== want && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    for (int s = 0; s < NS; s++)
      for (int r = 3*s; r < 3*s + 3; r++) m_up[s*NR + r] = 1'b1;
    m_nap[0] = 1; m_nap[1] = 1; m_nap[2*NR + 5] = 1; m_nap[3*NR + 11] = 1;
    m_dn[1*NR +: NR] = '1;
    m_wake[3*NR + 0] = 1; m_wake[3*NR + 1] = 1; m_wake[1*NR + 5] = 1; m_wake[1*NR + 11] = 1;
    t_up = {4'd3, 4'd2, 4'd1, 4'd0};
    t_dn = {4'd1, 4'd2, 4'd0, 4'd1};

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset enables", int'(en), 0);
    chk("R1 reset state", int'(st), 0);

    tag = "R2";
    pulse(1); pulse(2); pulse(3);
    repeat (4) @(negedge clk);
    chk("R2 illegal from off state", int'(st), 0);
    chk("R2 illegal from off enables", int'(en), 0);

    tag = "R4";
    timed_run(0, 2'b01, n);
    chk("R4 up duration 1+1+2+4+6", n, 14);
    chk("R3 all rails raised", int'(en), 12'hFFF);
    chk("R7 active after power-up", int'(st), 1);

    tag = "R2";
    pulse(3); pulse(0);
    repeat (4) @(negedge clk);
    chk("R2 wake/up ignored while active", int'(st), 1);

    tag = "R6";
    step_sel = 1; tick_mode = 1;
    pulse(2);
    repeat (2) @(negedge clk);
    tag = "R8";
    @(negedge clk);
    rq_dn = 1; rq_wake = 1;
    @(negedge clk);
    rq_dn = 0; rq_wake = 0;
    wait_st(2'b10);
    chk("R6 unmapped rails kept after sleep-entry", int'(en), 12'h7DC);
    @(negedge clk); @(negedge clk);
    chk("R8 held power-down beats sleep-exit", int'(st), 3);
    wait_st(2'b00);
    chk("R8 power-down completed", int'(en), 0);
    repeat (6) @(negedge clk);
    chk("R8 sleep-exit dropped", int'(st), 0);

    tag = "R5";
    tick_mode = 0; step_sel = 0;
    pulse(0); wait_st(2'b01);
    pulse(2); wait_st(2'b10);
    chk("R5 sleep-entry lowered mapped rails", int'(en), 12'h7DC);
    tick_mode = 1;
    pulse(3); wait_st(2'b01);
    chk("R5 sleep-exit raised mapped rails", int'(en), 12'hFFF);

    tag = "R4";
    tick_mode = 0; step_sel = 1; t_dn = {4'd1, 4'd1, 4'd1, 4'd1};
    @(negedge clk);
    timed_run(1, 2'b00, n);
    chk("R4 long step duration 1+4x8", n, 33);
    chk("R7 off after power-down", int'(en), 0);

    tag = "R3";
    tick_mode = 2; step_sel = 0;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R3 slot 0 waits for pulse", int'(en), 12'h007);
    tick_mode = 0;
    wait_st(2'b01);
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule